// File: doc/BRIEF.md
# SPI Serial Clock and Select Timing Generator

This block produces the serial clock and the chip-select framing for an SPI master. A sequencer hands it a one-cycle start pulse together with a frame length. On an accepted start the block samples its whole configuration. The configuration covers:

- an 8-bit rate value and a 2-bit per-command divider, which set the clock period;
- the clock polarity and phase;
- a select-keep flag;
- three 3-bit delay fields, each with its own enable: the lead delay from select to the first clock edge, the delay before select is released, and the gap before the next access.

After the start the block walks through a fixed sequence. It asserts select and waits the lead delay. It toggles the serial clock once per half period for the frame. It waits the release delay and drops select. It then waits the gap and pulses `done`. While the frame is running, it strobes the edges on which a partner shift register should sample or launch data.

All timing is counted in half periods of the serial clock. One prescaler supplies every phase, so each delay is an exact multiple of the clock period. Shift registers, buffers and the register interface sit outside this block.

Top module: `spi_timing_gen`

## Requirements
- R1: With `div_sel`=0 the serial clock period is 2×(`rate`+1) input clock cycles, so `rate`=0 gives half the input clock.
- R2: `div_sel` values 0, 1, 2 and 3 lengthen every half period by a factor of 1, 2, 4 and 8 respectively.
- R3: When its enable is set, each delay field (lead, release, gap) gives field+1 serial clock periods, covering 1 to 8.
- R4: When a delay's enable is clear, that delay lasts exactly one serial clock period whatever its field holds.
- R5: The sequence order is fixed: select rises in the cycle after an accepted start, together with `busy`; the lead delay follows, then the clock edges, then the release delay; select then falls and the gap follows. At the end `done` is high for one cycle, in the same cycle that `busy` falls.
- R6: `sck` rests at the `cpol` level whenever no clock edges are being produced. While idle it follows `cpol` one cycle later.
- R7: `sample_stb` is high in the cycle that `sck` takes each sampling edge, exactly once per bit. The sampling edge is the leading edge (away from idle) when `cpha`=0 and the trailing edge when `cpha`=1. `shift_stb` marks the remaining edges.
- R8: With `keep_sel` set, the release delay is skipped and select stays high after `done`. It stays high until a later command with `keep_sel` clear completes.
- R9: A start pulse arriving while `busy` is high is ignored: the running command's timing is unchanged and no further command is queued.
- R10: `frame_len` holds the bit count minus one, so a frame carries `frame_len`+1 bits and 2×(`frame_len`+1) clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle command start pulse |
| frame_len | input | 5 | Bits in the frame minus one |
| rate | input | 8 | Bit-rate value |
| div_sel | input | 2 | Per-command extra divider, 2^value |
| cpol | input | 1 | Idle level of sck |
| cpha | input | 1 | 0: sample on leading edge, 1: on trailing edge |
| keep_sel | input | 1 | Hold select at the end of this command |
| lead_dly | input | 3 | Select-to-clock delay field |
| lead_en | input | 1 | Enable for lead_dly |
| rel_dly | input | 3 | Release delay field |
| rel_en | input | 1 | Enable for rel_dly |
| gap_dly | input | 3 | Next-access gap field |
| gap_en | input | 1 | Enable for gap_dly |
| sck | output | 1 | Serial clock |
| sel | output | 1 | Chip select, high when asserted |
| sample_stb | output | 1 | Sampling-edge strobe |
| shift_stb | output | 1 | Launch-edge strobe |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest situation to reach is a select held across two commands. It needs one command that leaves select high and a second that finds it already asserted and must release it after its own release delay. The bench runs a keep command with a non-trivial release field, checks that the delay was skipped and that select is still high at `done`, then starts a second command at once. That second command must report select high on its first busy cycle. A second hard case is a start pulse that lands mid-command; the bench injects one and confirms that the completion time and the `done` count do not move.

// File: rtl/spi_tg_pkg.sv
package spi_tg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LEAD  = 3'd1,
    ST_SHIFT = 3'd2,
    ST_REL   = 3'd3,
    ST_GAP   = 3'd4
  } tg_state_e;
endpackage

// File: rtl/spi_tg_prescaler.sv
module spi_tg_prescaler #(
  parameter int PC_W = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic [PC_W-1:0] half_len,
  output logic            tick
);
  logic [PC_W-1:0] cnt;
  logic            at_end;

  assign at_end = (cnt == half_len - PC_W'(1));
  assign tick   = run && at_end;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (at_end) cnt <= '0;
    else             cnt <= cnt + PC_W'(1);
  end
endmodule

// File: rtl/spi_tg_seq.sv
module spi_tg_seq
  import spi_tg_pkg::*;
#(
  parameter int RATE_W = 8,
  parameter int DIV_W  = 2,
  parameter int DLY_W  = 3,
  parameter int BITS_W = 5,
  localparam int PC_W  = RATE_W + (1 << DIV_W),
  localparam int HC_W  = ((BITS_W > DLY_W) ? BITS_W : DLY_W) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [BITS_W-1:0] frame_len,
  input  logic [RATE_W-1:0] rate,
  input  logic [DIV_W-1:0]  div_sel,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              keep_sel,
  input  logic [DLY_W-1:0]  lead_dly,
  input  logic              lead_en,
  input  logic [DLY_W-1:0]  rel_dly,
  input  logic              rel_en,
  input  logic [DLY_W-1:0]  gap_dly,
  input  logic              gap_en,
  input  logic              tick,
  output logic [PC_W-1:0]   half_len,
  output logic              busy,
  output logic              sel,
  output logic              done,
  output logic              shifting,
  output logic              cpol_l,
  output logic              cpha_l
);
  tg_state_e         state;
  logic [HC_W-1:0]   hc;
  logic [BITS_W-1:0] len_l;
  logic [RATE_W-1:0] rate_l;
  logic [DIV_W-1:0]  div_l;
  logic              keep_l;
  logic [DLY_W-1:0]  lead_l, rel_l, gap_l;
  logic              lead_en_l, rel_en_l, gap_en_l;
  logic [HC_W-1:0]   lead_last, shift_last, rel_last, gap_last;

  // last half-period index of each phase: 2*periods - 1
  assign lead_last  = lead_en_l ? HC_W'({lead_l, 1'b1}) : HC_W'(1);
  assign rel_last   = rel_en_l  ? HC_W'({rel_l, 1'b1})  : HC_W'(1);
  assign gap_last   = gap_en_l  ? HC_W'({gap_l, 1'b1})  : HC_W'(1);
  assign shift_last = HC_W'({len_l, 1'b1});
  assign half_len   = PC_W'((PC_W'(rate_l) + PC_W'(1)) << div_l);
  assign shifting   = (state == ST_SHIFT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      hc        <= '0;
      busy      <= 1'b0;
      sel       <= 1'b0;
      done      <= 1'b0;
      len_l     <= '0;
      rate_l    <= '0;
      div_l     <= '0;
      cpol_l    <= 1'b0;
      cpha_l    <= 1'b0;
      keep_l    <= 1'b0;
      lead_l    <= '0;
      rel_l     <= '0;
      gap_l     <= '0;
      lead_en_l <= 1'b0;
      rel_en_l  <= 1'b0;
      gap_en_l  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          len_l     <= frame_len;
          rate_l    <= rate;
          div_l     <= div_sel;
          cpol_l    <= cpol;
          cpha_l    <= cpha;
          keep_l    <= keep_sel;
          lead_l    <= lead_dly;
          rel_l     <= rel_dly;
          gap_l     <= gap_dly;
          lead_en_l <= lead_en;
          rel_en_l  <= rel_en;
          gap_en_l  <= gap_en;
          hc        <= '0;
          sel       <= 1'b1;
          busy      <= 1'b1;
          state     <= ST_LEAD;
        end
        ST_LEAD: if (tick) begin
          if (hc == lead_last) begin
            hc    <= '0;
            state <= ST_SHIFT;
          end else hc <= hc + HC_W'(1);
        end
        ST_SHIFT: if (tick) begin
          if (hc == shift_last) begin
            hc    <= '0;
            state <= keep_l ? ST_GAP : ST_REL;
          end else hc <= hc + HC_W'(1);
        end
        ST_REL: if (tick) begin
          if (hc == rel_last) begin
            hc    <= '0;
            sel   <= 1'b0;
            state <= ST_GAP;
          end else hc <= hc + HC_W'(1);
        end
        ST_GAP: if (tick) begin
          if (hc == gap_last) begin
            hc    <= '0;
            busy  <= 1'b0;
            done  <= 1'b1;
            state <= ST_IDLE;
          end else hc <= hc + HC_W'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_tg_sck.sv
module spi_tg_sck (
  input  logic clk,
  input  logic rst,
  input  logic busy,
  input  logic shifting,
  input  logic tick,
  input  logic cpol,
  input  logic cpol_l,
  input  logic cpha_l,
  output logic sck,
  output logic sample_stb,
  output logic shift_stb
);
  logic leaving_idle;
  assign leaving_idle = (sck == cpol_l);

  always_ff @(posedge clk) begin
    if (rst) begin
      sck        <= cpol;
      sample_stb <= 1'b0;
      shift_stb  <= 1'b0;
    end else begin
      sample_stb <= 1'b0;
      shift_stb  <= 1'b0;
      if (!busy) sck <= cpol;
      else if (shifting && tick) begin
        sck <= ~sck;
        if (leaving_idle ^ cpha_l) sample_stb <= 1'b1;
        else                       shift_stb  <= 1'b1;
      end else if (!shifting) sck <= cpol_l;
    end
  end
endmodule

// File: rtl/spi_timing_gen.sv
module spi_timing_gen #(
  parameter int RATE_W = 8,
  parameter int DIV_W  = 2,
  parameter int DLY_W  = 3,
  parameter int BITS_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [BITS_W-1:0] frame_len,
  input  logic [RATE_W-1:0] rate,
  input  logic [DIV_W-1:0]  div_sel,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              keep_sel,
  input  logic [DLY_W-1:0]  lead_dly,
  input  logic              lead_en,
  input  logic [DLY_W-1:0]  rel_dly,
  input  logic              rel_en,
  input  logic [DLY_W-1:0]  gap_dly,
  input  logic              gap_en,
  output logic              sck,
  output logic              sel,
  output logic              sample_stb,
  output logic              shift_stb,
  output logic              busy,
  output logic              done
);
  localparam int PC_W = RATE_W + (1 << DIV_W);

  logic [PC_W-1:0] half_len;
  logic            tick, shifting, cpol_l, cpha_l;

  spi_tg_prescaler #(.PC_W(PC_W)) u_pre (
    .clk(clk), .rst(rst), .run(busy), .half_len(half_len), .tick(tick)
  );

  spi_tg_seq #(
    .RATE_W(RATE_W), .DIV_W(DIV_W), .DLY_W(DLY_W), .BITS_W(BITS_W)
  ) u_seq (
    .clk(clk), .rst(rst), .start(start), .frame_len(frame_len),
    .rate(rate), .div_sel(div_sel), .cpol(cpol), .cpha(cpha),
    .keep_sel(keep_sel), .lead_dly(lead_dly), .lead_en(lead_en),
    .rel_dly(rel_dly), .rel_en(rel_en), .gap_dly(gap_dly), .gap_en(gap_en),
    .tick(tick), .half_len(half_len), .busy(busy), .sel(sel), .done(done),
    .shifting(shifting), .cpol_l(cpol_l), .cpha_l(cpha_l)
  );

  spi_tg_sck u_sck (
    .clk(clk), .rst(rst), .busy(busy), .shifting(shifting), .tick(tick),
    .cpol(cpol), .cpol_l(cpol_l), .cpha_l(cpha_l),
    .sck(sck), .sample_stb(sample_stb), .shift_stb(shift_stb)
  );
endmodule

// File: rtl/spi_timing_gen_chk.sv
module spi_timing_gen_chk (
  input logic clk,
  input logic rst,
  input logic cpol,
  input logic sck,
  input logic sel,
  input logic sample_stb,
  input logic shift_stb,
  input logic busy,
  input logic done
);
  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R5
  busy_end_done_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);
  // R5
  busy_start_sel_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> sel);
  // R6
  idle_level_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(busy) |-> (sck == $past(cpol)));
  // R6
  quiet_unselected_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !sel) |-> $stable(sck));
  // R7
  strobe_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
    (sample_stb || shift_stb) |-> (busy && sel && !$stable(sck)));
  // R7
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(sample_stb && shift_stb));
endmodule

bind spi_timing_gen spi_timing_gen_chk u_chk (
  .clk(clk), .rst(rst), .cpol(cpol), .sck(sck), .sel(sel),
  .sample_stb(sample_stb), .shift_stb(shift_stb), .busy(busy), .done(done)
);

// File: tb/spi_timing_gen_bench.sv
`timescale 1ns/1ps
module spi_timing_gen_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [4:0] frame_len = '0;
  logic [7:0] rate = '0;
  logic [1:0] div_sel = '0;
  logic       cpol = 1'b0, cpha = 1'b0, keep_sel = 1'b0;
  logic [2:0] lead_dly = '0, rel_dly = '0, gap_dly = '0;
  logic       lead_en = 1'b0, rel_en = 1'b0, gap_en = 1'b0;
  logic       sck, sel, sample_stb, shift_stb, busy, done;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  spi_timing_gen u_spi_timing_gen (
    .clk(clk), .rst(rst), .start(start), .frame_len(frame_len),
    .rate(rate), .div_sel(div_sel), .cpol(cpol), .cpha(cpha),
    .keep_sel(keep_sel), .lead_dly(lead_dly), .lead_en(lead_en),
    .rel_dly(rel_dly), .rel_en(rel_en), .gap_dly(gap_dly), .gap_en(gap_en),
    .sck(sck), .sel(sel), .sample_stb(sample_stb), .shift_stb(shift_stb),
    .busy(busy), .done(done)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // measurement record of one command, indices counted from the first busy cycle
  int m_busy0, m_sel0, m_first_tog, m_togs, m_smps, m_first_smp;
  int m_selfall, m_done_idx, m_done_cnt, m_sck_end, m_sel_end;

  task automatic exec(input int r, input int d, input bit cp, input bit ch, input bit kp,
                      input int ld, input bit le, input int rd, input bit re,
                      input int gd, input bit ge, input int fl, input bit poke);
    int  idx;
    bit  fin;
    logic prev_sck, prev_sel;
    @(negedge clk);
    rate = 8'(r); div_sel = 2'(d); cpol = cp; cpha = ch; keep_sel = kp;
    lead_dly = 3'(ld); lead_en = le; rel_dly = 3'(rd); rel_en = re;
    gap_dly = 3'(gd); gap_en = ge; frame_len = 5'(fl);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    idx = 0; fin = 0;
    m_busy0 = int'(busy); m_sel0 = int'(sel);
    m_first_tog = -1; m_togs = 0; m_smps = 0; m_first_smp = -1;
    m_selfall = -1; m_done_idx = -1; m_done_cnt = 0; m_sck_end = -1; m_sel_end = -1;
    prev_sck = sck; prev_sel = sel;
    while (!fin && idx < 20000) begin
      @(negedge clk);
      idx++;
      if (poke) start = (idx == 3);
      if (sck != prev_sck) begin
        m_togs++;
        if (m_first_tog < 0) m_first_tog = idx;
      end
      prev_sck = sck;
      if (sample_stb) begin
        m_smps++;
        if (m_first_smp < 0) m_first_smp = idx;
      end
      if (prev_sel && !sel && m_selfall < 0) m_selfall = idx;
      prev_sel = sel;
      if (done) begin
        m_done_cnt++; m_done_idx = idx;
        m_sck_end = int'(sck); m_sel_end = int'(sel);
        fin = 1;
      end
    end
    start = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R6", "sck after reset", int'(sck), 0);
    chk("R5", "sel after reset", int'(sel), 0);
    chk("R5", "busy after reset", int'(busy), 0);
    chk("R5", "done after reset", int'(done), 0);
  endtask

  task automatic t_basic();
    // H=1, all delays disabled with max fields, 8 bits
    exec(0, 0, 0, 0, 0, 7, 0, 7, 0, 7, 0, 7, 0);
    chk("R5", "busy at first cycle", m_busy0, 1);
    chk("R5", "sel at first cycle", m_sel0, 1);
    chk("R4", "first edge index", m_first_tog, 3);
    chk("R10", "edge count", m_togs, 16);
    chk("R4", "select fall index", m_selfall, 20);
    chk("R1", "done index", m_done_idx, 22);
    chk("R5", "sel low at done", m_sel_end, 0);
    chk("R7", "sample strobes", m_smps, 8);
    chk("R7", "first sample cpha0", m_first_smp, 3);
  endtask

  task automatic t_rate();
    // H=3, lead 2, release 4, gap 7 periods, 4 bits, mode 3
    exec(2, 0, 1, 1, 0, 1, 1, 3, 1, 6, 1, 3, 0);
    chk("R3", "first edge index", m_first_tog, 15);
    chk("R3", "select fall index", m_selfall, 60);
    chk("R1", "done index", m_done_idx, 102);
    chk("R6", "sck idle high at done", m_sck_end, 1);
    chk("R7", "sample strobes", m_smps, 4);
    chk("R7", "first sample cpha1", m_first_smp, 18);
  endtask

  task automatic t_div();
    // rate 1, divider 8 -> H=16, 2 bits
    exec(1, 3, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    chk("R2", "first edge index", m_first_tog, 48);
    chk("R2", "done index", m_done_idx, 160);
    // rate 0, divider 2 -> H=2
    exec(0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R2", "done index div2", m_done_idx, 16);
  endtask

  task automatic t_maxdly();
    exec(0, 0, 0, 0, 0, 7, 1, 7, 1, 7, 1, 31, 0);
    chk("R3", "first edge index", m_first_tog, 17);
    chk("R10", "edge count 32 bits", m_togs, 64);
    chk("R3", "done index", m_done_idx, 112);
  endtask

  task automatic t_keep();
    exec(0, 0, 0, 0, 1, 0, 0, 4, 1, 0, 0, 0, 0);
    chk("R8", "no select fall", m_selfall, -1);
    chk("R8", "release skipped done index", m_done_idx, 6);
    chk("R8", "sel held at done", m_sel_end, 1);
    exec(0, 0, 0, 0, 0, 0, 0, 4, 1, 0, 0, 0, 0);
    chk("R8", "sel already high", m_sel0, 1);
    chk("R8", "select fall index", m_selfall, 14);
    chk("R8", "done index", m_done_idx, 16);
    chk("R8", "sel low at done", m_sel_end, 0);
  endtask

  task automatic t_busy_start();
    int extra;
    exec(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 2, 1);
    chk("R9", "done index", m_done_idx, 24);
    chk("R9", "edge count", m_togs, 6);
    extra = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (busy || done) extra++;
    end
    chk("R9", "no queued command", extra, 0);
  endtask

  task automatic t_idle_pol();
    @(negedge clk); cpol = 1'b1;
    @(negedge clk);
    chk("R6", "idle sck follows cpol high", int'(sck), 1);
    cpol = 1'b0;
    @(negedge clk);
    chk("R6", "idle sck follows cpol low", int'(sck), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_basic();
    t_rate();
    t_div();
    t_maxdly();
    t_keep();
    t_busy_start();
    t_idle_pol();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(4 * 200000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule